// File: doc/BRIEF.md
# Two-of-Twelve Track Rank Selector

This block takes a set of candidate track words, up to twelve per clock, each with a valid flag. Duplicates have already been removed upstream. It forwards the two best-ranked tracks. A track's rank is an 8-bit key cut from its own word: a 3-bit quality field sits above a 5-bit transverse-momentum field, so quality always dominates.

The selection is fully parallel. Every pair of inputs is compared once, which gives 66 comparators for twelve inputs, and the comparator outcomes are registered as a win matrix. In the next cycle, logic equations turn that matrix straight into two one-hot selection vectors, one for the first choice and one for the second. Two AND-OR multiplexers then route the chosen words into the output registers.

A fresh input set is accepted every clock, and its result appears exactly two clocks later. The block is meant to sit between duplicate cancellation and the link that carries the winners to the next sorting stage.

Top module: `rank2_selector`

## Requirements
- R1: The rank of a track is its bits [30:28] (quality) concatenated above bits [27:23] (momentum), compared as an unsigned 8-bit number; a higher rank is better, so any higher quality beats any momentum.
- R2: The first output carries, unchanged in all 31 bits, the valid input of highest rank, with its valid flag high.
- R3: The second output carries, unchanged, the valid input of highest rank among the remaining inputs, with its valid flag high when at least two inputs are valid.
- R4: When two valid inputs have equal rank, the one with the lower index is preferred, for both the first and the second choice.
- R5: An input whose valid flag is low is never selected, whatever its word holds; a valid track of rank zero is preferred over any invalid input.
- R6: When fewer than two inputs are valid, each unused output is all zeros with its valid flag low; with no valid input, both outputs are like that.
- R7: The result for an input set appears on the outputs exactly two clock edges after the set is sampled, and a new set may be presented on every clock.
- R8: Whenever both outputs are valid, the rank of the first is greater than or equal to the rank of the second; the second output is never valid while the first is not.
- R9: While reset is asserted, both outputs are all zeros with valid flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_trk | input | N_TRK*31 (372) | Candidate track words, input i at bits [i*31 +: 31] |
| in_vld | input | N_TRK (12) | Valid flag per candidate |
| out1_trk | output | 31 | Best track word |
| out1_vld | output | 1 | Best track present |
| out2_trk | output | 31 | Second-best track word |
| out2_vld | output | 1 | Second-best track present |

## Verification
The assertions check four properties on every cycle:
- each decoded selection vector is exactly one-hot, and the first and second picks never coincide;
- the two outputs stay in rank order, and the second output is valid only when the first is;
- any valid input produces a valid first output two edges later, and an empty input set produces zeroed outputs two edges later;
- an unused output slot holds zeros.

Only the bench scenarios can show that the right track was chosen and that its word arrives intact. They cover the precedence of quality over momentum, the lower-index choice on ties, the rejection of invalid inputs that carry large ranks, and cycle-exact latency across back-to-back input sets.

// File: rtl/rank_sel_pkg.sv
package rank_sel_pkg;
  localparam int TRK_W   = 31;
  localparam int QUAL_W  = 3;
  localparam int PT_W    = 5;
  localparam int RANK_W  = QUAL_W + PT_W;
  localparam int RANK_HI = TRK_W - 1;          // quality sits at the top of the word
  localparam int KEY_W   = RANK_W + 1;         // valid flag above the rank

  // 8-bit rank: quality above momentum
  function automatic logic [RANK_W-1:0] trk_rank(input logic [TRK_W-1:0] t);
    return t[RANK_HI -: RANK_W];
  endfunction

  // sort key: invalid inputs fall below every valid one
  function automatic logic [KEY_W-1:0] sort_key(input logic v, input logic [TRK_W-1:0] t);
    return v ? {1'b1, trk_rank(t)} : '0;
  endfunction
endpackage

// File: rtl/rank_pair_matrix.sv
module rank_pair_matrix
  import rank_sel_pkg::*;
#(
  parameter int N = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N*TRK_W-1:0] in_trk,
  input  logic [N-1:0]       in_vld,
  output logic [N*N-1:0]     beats_q,   // beats_q[i*N+j]: input i preferred over j
  output logic [N*TRK_W-1:0] trk_q,
  output logic [N-1:0]       vld_q
);
  localparam int NCMP = N * (N - 1) / 2;

  logic [KEY_W-1:0] key [N];
  logic [N*N-1:0]   beats_d;
  logic [N*N-1:0]   beats_rst;

  for (genvar i = 0; i < N; i++) begin : g_key
    assign key[i] = sort_key(in_vld[i], in_trk[i*TRK_W +: TRK_W]);
  end

  // one comparator per unordered pair; the mirror entry is its complement
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign beats_d[i*N+j]   = 1'b0;
        assign beats_rst[i*N+j] = 1'b0;
      end else if (i < j) begin : g_cmp
        assign beats_d[i*N+j]   = (key[i] >= key[j]);   // tie: lower index wins
        assign beats_rst[i*N+j] = 1'b1;
      end else begin : g_mirror
        assign beats_d[i*N+j]   = ~beats_d[j*N+i];
        assign beats_rst[i*N+j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_q <= beats_rst;
      vld_q   <= '0;
      trk_q   <= '0;
    end else begin
      beats_q <= beats_d;
      vld_q   <= in_vld;
      for (int i = 0; i < N; i++)
        trk_q[i*TRK_W +: TRK_W] <= in_vld[i] ? in_trk[i*TRK_W +: TRK_W] : '0;
    end
  end

  // a registered matrix must be a strict total order on every pair
  for (genvar i = 0; i < N; i++) begin : g_chk_row
    for (genvar j = i + 1; j < N; j++) begin : g_chk_col
      AST_PAIR_ANTISYM: assert property (@(posedge clk) disable iff (!rst_n)
        beats_q[i*N+j] != beats_q[j*N+i]);  // R4
    end
  end

  initial begin
    if (NCMP < 1) $error("rank_pair_matrix needs at least two inputs");
  end
endmodule

// File: rtl/rank_sel_decode.sv
module rank_sel_decode #(
  parameter int N = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] beats,
  output logic [N-1:0]   first_sel,
  output logic [N-1:0]   second_sel
);
  logic term;

  // first: beats every other input
  // second: beats all but exactly one k, and that k beats it
  always_comb begin
    first_sel  = '1;
    second_sel = '0;
    term       = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++)
        if (j != i) first_sel[i] = first_sel[i] & beats[i*N+j];
      for (int k = 0; k < N; k++) begin
        if (k != i) begin
          term = beats[k*N+i];
          for (int j = 0; j < N; j++)
            if (j != i && j != k) term = term & beats[i*N+j];
          second_sel[i] = second_sel[i] | term;
        end
      end
    end
  end

  AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(first_sel));  // R2
  AST_SECOND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(second_sel));  // R3
  AST_PICKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_sel & second_sel) == '0);  // R3
endmodule

// File: rtl/rank_sel_mux.sv
module rank_sel_mux
  import rank_sel_pkg::*;
#(
  parameter int N = 12
) (
  input  logic [N-1:0]       sel,
  input  logic [N*TRK_W-1:0] trk,
  input  logic [N-1:0]       vld,
  output logic [TRK_W-1:0]   out_trk,
  output logic               out_vld
);
  always_comb begin
    out_trk = '0;
    out_vld = 1'b0;
    for (int i = 0; i < N; i++) begin
      out_trk = out_trk | (trk[i*TRK_W +: TRK_W] & {TRK_W{sel[i]}});
      out_vld = out_vld | (vld[i] & sel[i]);
    end
  end
endmodule

// File: rtl/rank2_selector.sv
module rank2_selector
  import rank_sel_pkg::*;
#(
  parameter int N_TRK = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_TRK*TRK_W-1:0] in_trk,
  input  logic [N_TRK-1:0]       in_vld,
  output logic [TRK_W-1:0]       out1_trk,
  output logic                   out1_vld,
  output logic [TRK_W-1:0]       out2_trk,
  output logic                   out2_vld
);
  logic [N_TRK*N_TRK-1:0] beats_q;
  logic [N_TRK*TRK_W-1:0] trk_q;
  logic [N_TRK-1:0]       vld_q;
  logic [N_TRK-1:0]       first_sel;
  logic [N_TRK-1:0]       second_sel;
  logic [TRK_W-1:0]       pick1_trk;
  logic [TRK_W-1:0]       pick2_trk;
  logic                   pick1_vld;
  logic                   pick2_vld;

  // cycle 1: all-pairs comparison
  rank_pair_matrix #(.N(N_TRK)) u_matrix (
    .clk(clk), .rst_n(rst_n), .in_trk(in_trk), .in_vld(in_vld),
    .beats_q(beats_q), .trk_q(trk_q), .vld_q(vld_q)
  );

  // cycle 2: decode and route
  rank_sel_decode #(.N(N_TRK)) u_decode (
    .clk(clk), .rst_n(rst_n), .beats(beats_q),
    .first_sel(first_sel), .second_sel(second_sel)
  );

  rank_sel_mux #(.N(N_TRK)) u_mux1 (
    .sel(first_sel), .trk(trk_q), .vld(vld_q),
    .out_trk(pick1_trk), .out_vld(pick1_vld)
  );

  rank_sel_mux #(.N(N_TRK)) u_mux2 (
    .sel(second_sel), .trk(trk_q), .vld(vld_q),
    .out_trk(pick2_trk), .out_vld(pick2_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out1_trk <= '0;
      out1_vld <= 1'b0;
      out2_trk <= '0;
      out2_vld <= 1'b0;
    end else begin
      out1_trk <= pick1_trk;
      out1_vld <= pick1_vld;
      out2_trk <= pick2_trk;
      out2_vld <= pick2_vld;
    end
  end

  AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out1_vld && out2_vld) |-> (trk_rank(out1_trk) >= trk_rank(out2_trk)));  // R8
  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    out2_vld |-> out1_vld);  // R8
  AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_vld) |-> ##2 out1_vld);  // R7
  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld == '0) |-> ##2 (!out1_vld && out1_trk == '0));  // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out2_vld |-> (out2_trk == '0));  // R6
endmodule

// File: tb/rank2_selector_bench.sv
module rank2_selector_bench;
  localparam int N = 12;
  localparam int W = 31;
  localparam int NSTREAM = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*W-1:0] in_trk;
  logic [N-1:0]   in_vld;
  logic [W-1:0]   out1_trk, out2_trk;
  logic           out1_vld, out2_vld;

  logic [W-1:0]   bt [N];
  logic [N-1:0]   bv;
  int             errors = 0;
  int             checks = 0;
  logic [31:0]    lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) in_trk[i*W +: W] = bt[i];
    in_vld = bv;
  end

  rank2_selector u_rank2_selector (
    .clk(clk), .rst_n(rst_n), .in_trk(in_trk), .in_vld(in_vld),
    .out1_trk(out1_trk), .out1_vld(out1_vld),
    .out2_trk(out2_trk), .out2_vld(out2_vld)
  );

  // build a word from quality, momentum and filler bits
  function automatic logic [W-1:0] mk(input int q, input int pt, input logic [22:0] rest);
    logic [2:0] qq;
    logic [4:0] pp;
    qq = q[2:0];
    pp = pt[4:0];
    return {qq, pp, rest};
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // scan for the best and the runner-up; strict > keeps the lower index on ties
  task automatic model(output logic [W-1:0] e1, output logic v1,
                       output logic [W-1:0] e2, output logic v2);
    int b1 = -1;
    int b2 = -1;
    for (int i = 0; i < N; i++)
      if (bv[i] && (b1 < 0 || bt[i][30:23] > bt[b1][30:23])) b1 = i;
    for (int i = 0; i < N; i++)
      if (i != b1 && bv[i] && (b2 < 0 || bt[i][30:23] > bt[b2][30:23])) b2 = i;
    e1 = (b1 >= 0) ? bt[b1] : '0;
    v1 = (b1 >= 0);
    e2 = (b2 >= 0) ? bt[b2] : '0;
    v2 = (b2 >= 0);
  endtask

  task automatic check(input string req, input logic [W-1:0] at, input logic av,
                       input logic [W-1:0] et, input logic ev);
    checks++;
    if (at !== et || av !== ev) begin
      errors++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", req, at, av, et, ev);
    end
  endtask

  task automatic clear_set();
    for (int i = 0; i < N; i++) bt[i] = '0;
    bv = '0;
  endtask

  // drive one set, wait two edges, compare both outputs with the model
  task automatic run_set(input string req);
    logic [W-1:0] e1, e2;
    logic v1, v2;
    model(e1, v1, e2, v2);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check({req, " first"}, out1_trk, out1_vld, e1, v1);
    check({req, " second"}, out2_trk, out2_vld, e2, v2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 out1 in reset", out1_trk, out1_vld, '0, 1'b0);
    check("R9 out2 in reset", out2_trk, out2_vld, '0, 1'b0);
  endtask

  task automatic t_distinct();
    @(negedge clk);
    clear_set();
    for (int i = 0; i < N; i++) begin
      bt[i] = mk(i % 8, (i * 7) % 32, 23'(32'h5A5A00 + i));
      bv[i] = 1'b1;
    end
    run_set("R2 R3 distinct");
    check("R2 word intact", out1_trk, out1_vld, mk(7, 17, 23'h5A5A07), 1'b1);
  endtask

  task automatic t_quality_first();
    @(negedge clk);
    clear_set();
    bt[2] = mk(4, 31, 23'h7FFFFF); bv[2] = 1'b1;
    bt[9] = mk(5, 0, 23'h000123);  bv[9] = 1'b1;
    bt[5] = mk(4, 30, 23'h0ABCDE); bv[5] = 1'b1;
    run_set("R1 quality over momentum");
    check("R1 first is high quality", out1_trk, out1_vld, mk(5, 0, 23'h000123), 1'b1);
  endtask

  task automatic t_ties();
    @(negedge clk);
    clear_set();
    for (int i = 0; i < N; i++) begin
      bt[i] = mk(3, 9, 23'(i + 1));
      bv[i] = 1'b1;
    end
    run_set("R4 all tied");
    check("R4 tie index0", out1_trk, out1_vld, mk(3, 9, 23'd1), 1'b1);
    check("R4 tie index1", out2_trk, out2_vld, mk(3, 9, 23'd2), 1'b1);
    @(negedge clk);
    clear_set();
    bt[7] = mk(6, 6, 23'h77); bv[7] = 1'b1;
    bt[3] = mk(6, 6, 23'h33); bv[3] = 1'b1;
    bt[0] = mk(1, 1, 23'h11); bv[0] = 1'b1;
    run_set("R4 pair tie");
  endtask

  task automatic t_invalid();
    @(negedge clk);
    clear_set();
    for (int i = 0; i < N; i++) bt[i] = mk(7, 31, 23'h7FFFFF);
    bt[4]  = mk(0, 0, 23'h000444); bv[4]  = 1'b1;
    bt[10] = mk(0, 3, 23'h000AAA); bv[10] = 1'b1;
    run_set("R5 invalid ignored");
    check("R5 rank-zero valid wins", out2_trk, out2_vld, mk(0, 0, 23'h000444), 1'b1);
  endtask

  task automatic t_sparse();
    @(negedge clk);
    clear_set();
    bt[0] = mk(7, 31, 23'h1);
    bt[11] = mk(2, 5, 23'h0BEEF); bv[11] = 1'b1;
    run_set("R6 one valid");
    check("R6 unused zero", out2_trk, out2_vld, '0, 1'b0);
    @(negedge clk);
    clear_set();
    bt[6] = mk(7, 31, 23'h66);
    run_set("R6 none valid");
  endtask

  task automatic t_stream();
    logic [W-1:0] e1 [NSTREAM];
    logic [W-1:0] e2 [NSTREAM];
    logic         v1 [NSTREAM];
    logic         v2 [NSTREAM];
    for (int k = 0; k < NSTREAM + 2; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R7 stream first", out1_trk, out1_vld, e1[k-2], v1[k-2]);
        check("R7 stream second", out2_trk, out2_vld, e2[k-2], v2[k-2]);
        checks++;
        if (out1_vld && out2_vld && out1_trk[30:23] < out2_trk[30:23]) begin
          errors++;
          $display("FAIL R8 actual=%h<%h expected=ordered", out1_trk[30:23], out2_trk[30:23]);
        end
      end
      if (k < NSTREAM) begin
        for (int i = 0; i < N; i++) begin
          lfsr = step(lfsr);
          lfsr = step(lfsr);
          bt[i] = {lfsr[30:29] & 2'(k % 4), lfsr[28:0]};
          bv[i] = lfsr[31] | lfsr[7];
        end
        model(e1[k], v1[k], e2[k], v2[k]);
      end
    end
  endtask

  initial begin
    clear_set();
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_distinct();
    t_quality_first();
    t_ties();
    t_invalid();
    t_sparse();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule